// File: doc/BRIEF.md
# SPI Bitstream Programming Sequencer

This block runs a complete in-system programming session over SPI. When software pulses `start`, the block does the following in order:

- It turns on configuration access and fetches a four-byte acknowledgement, which must be zero.
- It switches the target into program mode.
- It streams the bitstream as 16-byte frames, each frame led by its own frame opcode.
- It turns configuration access off, waits about a millisecond, and then releases the target.

Before each command the block reads the target's status register. It repeats that read until the busy flag is clear. Before the data fetch it also waits for the ready flag.

Bitstream bytes enter through a valid/ready stream. The total byte count is given with `start`, and a count that is not a whole number of frames is refused at once. The block reports progress on these outputs:

- `busy` is high for the whole session.
- `done` pulses for one cycle when the session ends, whether it succeeded or failed.
- `errCode` names the phase that failed.
- `progMode` follows whether the target has been placed in program mode.

Top module: `spiProgSeq`

## Requirements
- R1: When `start` arrives with `byteCount[3:0]` nonzero, the next cycle shows `done` high and `errCode` = 1, and chip select is never asserted.
- R2: A session sends its commands in this order, each in a chip-select window of its own:
  - 0x0B (configuration on);
  - 0x01 followed by four dummy bytes (data fetch);
  - 0xAE 0x01 (program mode);
  - one 0xEE window for each 16 bytes;
  - 0x0C (configuration off);
  - 0x23 (release).
  
  SPI runs in mode 0, MSB first.
- R3: Every command window is preceded by a status poll. A status poll is two one-byte windows carrying opcode 0x00, and the target answers with its status byte in the first byte of each window. The command is sent only when bit 0 (busy) of the second answer is clear. While busy is set, the poll repeats.
- R4: The poll before the 0x01 data fetch also requires bit 1 (ready) of the status byte to be set.
- R5: If the OR of the four reply bytes of the data fetch is nonzero, the session aborts with `errCode` = 3 and sends no further command.
- R6: Each 0xEE window carries the next 16 stream bytes in arrival order. A byte is taken only on a cycle with `inValid` and `inReady` both high, and exactly `byteCount` bytes are consumed.
- R7: `progMode` goes high after the 0xAE 0x01 window and low after the 0x23 window. It changes only while `busy` is high.
- R8: After the 0x0C window, chip select stays high for at least `CLK_HZ/1000 + 1` cycles before the poll that leads to release.
- R9: A second status answer with bit 2 or bit 3 set aborts the session. `errCode` then names the phase that was being polled: 2 configuration on, 3 data fetch, 4 program mode, 5 frame, 6 configuration off, 7 release. Chip select returns high.
- R10: After `POLL_TRIES` polls that all report a busy or not-ready target, the session aborts with the phase code of R9.
- R11: After reset, `spiCsN` = 1 and `busy`, `done`, `errCode`, `progMode` and `inReady` are all 0. `done` is a single-cycle pulse, and `errCode` = 0 after a successful session.
- R12: The first status answer of each poll pair is ignored, even when its error bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session (taken while idle) |
| byteCount | input | BYTES_W | Bitstream length in bytes, sampled with start |
| inData | input | 8 | Bitstream byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Sequencer takes inData this cycle if inValid |
| spiSclk | output | 1 | SPI clock, half the system clock rate |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data to target |
| spiMiso | input | 1 | SPI data from target |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| errCode | output | 4 | Failed phase, 0 when the session succeeded |
| progMode | output | 1 | Target is in program mode |

## Verification
The bench builds the block with the following parameters:
- `CLK_HZ` = 50000 shrinks the release delay to 51 cycles, so R8 can be measured exactly inside a short run.
- `POLL_TRIES` = 8 lets a permanently busy target reach the timeout of R10 after 16 status windows.
- `BYTES_W` = 12 still allows multi-frame sessions.

A target model answers each window. It can inject busy and not-ready responses, error bits starting after a chosen command, bad first reads within a poll pair, and nonzero fetch replies. With these it drives every abort phase and the poll-retry paths.

// File: rtl/spiProgPkg.sv
package spiProgPkg;

  // Phase codes double as the error code of a failed session.
  typedef enum logic [3:0] {
    PH_NONE = 4'd0,
    PH_LEN  = 4'd1,
    PH_EN   = 4'd2,
    PH_RD   = 4'd3,
    PH_PRG  = 4'd4,
    PH_FRM  = 4'd5,
    PH_DIS  = 4'd6,
    PH_REL  = 4'd7
  } phase_t;

  typedef enum logic [1:0] {W_ST1, W_ST2, W_CMD} window_t;

  typedef struct packed {
    logic       load;
    logic [7:0] data;
  } shiftCmd_t;

  localparam logic [7:0] OP_STATUS  = 8'h00;
  localparam logic [7:0] OP_FETCH   = 8'h01;
  localparam logic [7:0] OP_CFG_ON  = 8'h0B;
  localparam logic [7:0] OP_CFG_OFF = 8'h0C;
  localparam logic [7:0] OP_MODESEL = 8'hAE;
  localparam logic [7:0] OP_PRGARG  = 8'h01;
  localparam logic [7:0] OP_FRAME   = 8'hEE;
  localparam logic [7:0] OP_RELEASE = 8'h23;
  localparam int         FRAME_BYTES = 16;

  function automatic logic [4:0] windowLen(phase_t p);
    case (p)
      PH_RD:   return 5'd5;
      PH_PRG:  return 5'd2;
      PH_FRM:  return 5'(FRAME_BYTES + 1);
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [7:0] cmdByte(phase_t p, logic [4:0] idx);
    logic first;
    first = (idx == 5'd0);
    case (p)
      PH_EN:   return OP_CFG_ON;
      PH_RD:   return first ? OP_FETCH : 8'h00;
      PH_PRG:  return first ? OP_MODESEL : OP_PRGARG;
      PH_FRM:  return OP_FRAME;
      PH_DIS:  return OP_CFG_OFF;
      PH_REL:  return OP_RELEASE;
      default: return OP_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/spiProgShifter.sv
module spiProgShifter
  import spiProgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  shiftCmd_t  cmd,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  logic [7:0] txReg;
  logic [2:0] bitCnt;
  logic       active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      rxByte   <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      sclk     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.load) begin
        txReg  <= cmd.data;
        bitCnt <= '0;
        active <= 1'b1;
        sclk   <= 1'b0;
      end else if (active) begin
        if (!sclk) begin
          sclk   <= 1'b1;
          rxByte <= {rxByte[6:0], miso};
        end else begin
          sclk   <= 1'b0;
          txReg  <= {txReg[6:0], 1'b0};
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi = txReg[7];

  // R2
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !active);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !sclk);

endmodule

// File: rtl/spiProgCtrl.sv
module spiProgCtrl
  import spiProgPkg::*;
#(
  parameter int BYTES_W     = 24,
  parameter int POLL_TRIES  = 4096,
  parameter int WAIT_CYCLES = 50001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BYTES_W-1:0] byteCount,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  input  logic               byteDone,
  input  logic [7:0]         rxByte,
  output shiftCmd_t          cmd,
  output logic               csN,
  output logic               busy,
  output logic               done,
  output logic [3:0]         errCode,
  output logic               progMode
);
  localparam int FR_W   = BYTES_W - 4;
  localparam int TRY_W  = $clog2(POLL_TRIES + 1);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_WAIT} state_t;

  state_t            state;
  window_t           winKind;
  phase_t            phase;
  logic [4:0]        byteIdx;
  logic              issued;
  logic [FR_W-1:0]   framesLeft;
  logic [TRY_W-1:0]  tries;
  logic [WAIT_W-1:0] waitCnt;
  logic [7:0]        statusReg;
  logic [7:0]        replyOr;

  logic       isData, canIssue, needReady, statOk, statFault;
  logic [4:0] lastIdx;

  always_comb begin
    isData    = (winKind == W_CMD) && (phase == PH_FRM) && (byteIdx != 5'd0);
    canIssue  = (state == S_XFER) && !issued;
    inReady   = canIssue && isData;
    cmd.load  = canIssue && (!isData || inValid);
    cmd.data  = isData ? inData : ((winKind == W_CMD) ? cmdByte(phase, byteIdx) : OP_STATUS);
    lastIdx   = (winKind == W_CMD) ? windowLen(phase) - 5'd1 : 5'd0;
    needReady = (phase == PH_RD);
    statFault = |statusReg[3:2];
    statOk    = !statusReg[0] && (!needReady || statusReg[1]);
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      winKind    <= W_ST1;
      phase      <= PH_NONE;
      byteIdx    <= '0;
      issued     <= 1'b0;
      framesLeft <= '0;
      tries      <= '0;
      waitCnt    <= '0;
      statusReg  <= '0;
      replyOr    <= '0;
      csN        <= 1'b1;
      done       <= 1'b0;
      errCode    <= '0;
      progMode   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (|byteCount[3:0]) begin
            errCode <= 4'(PH_LEN);
            done    <= 1'b1;
          end else begin
            errCode    <= '0;
            framesLeft <= byteCount[BYTES_W-1:4];
            phase      <= PH_EN;
            winKind    <= W_ST1; tries <= '0; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
          end
        end
        S_XFER: begin
          if (byteDone) begin
            issued <= 1'b0;
            if (winKind != W_CMD) statusReg <= rxByte;
            else if (phase == PH_RD && byteIdx != 5'd0) replyOr <= replyOr | rxByte;
            if (byteIdx == lastIdx) begin
              csN   <= 1'b1;
              state <= S_GAP;
            end else begin
              byteIdx <= byteIdx + 5'd1;
            end
          end else if (cmd.load) begin
            issued <= 1'b1;
          end
        end
        S_GAP: begin
          case (winKind)
            W_ST1: begin
              winKind <= W_ST2; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
            end
            W_ST2: begin
              if (statFault) begin
                errCode <= 4'(phase); done <= 1'b1; state <= S_IDLE;
              end else if (statOk) begin
                winKind <= W_CMD; replyOr <= '0; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
              end else if (tries == TRY_W'(POLL_TRIES - 1)) begin
                errCode <= 4'(phase); done <= 1'b1; state <= S_IDLE;
              end else begin
                tries <= tries + 1'b1;
                winKind <= W_ST1; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
              end
            end
            default: begin
              winKind <= W_ST1; tries <= '0; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
              case (phase)
                PH_EN: phase <= PH_RD;
                PH_RD: if (replyOr != 8'h00) begin
                  errCode <= 4'(PH_RD); done <= 1'b1; csN <= 1'b1; state <= S_IDLE;
                end else begin
                  phase <= PH_PRG;
                end
                PH_PRG: begin
                  progMode <= 1'b1;
                  phase    <= (framesLeft == '0) ? PH_DIS : PH_FRM;
                end
                PH_FRM: begin
                  framesLeft <= framesLeft - 1'b1;
                  phase      <= (framesLeft == FR_W'(1)) ? PH_DIS : PH_FRM;
                end
                PH_DIS: begin
                  csN <= 1'b1; waitCnt <= '0; state <= S_WAIT;
                end
                default: begin
                  progMode <= 1'b0; done <= 1'b1; csN <= 1'b1;
                  phase <= PH_NONE; state <= S_IDLE;
                end
              endcase
            end
          endcase
        end
        default: begin
          if (waitCnt == WAIT_W'(WAIT_CYCLES - 1)) begin
            phase   <= PH_REL;
            winKind <= W_ST1; tries <= '0; byteIdx <= '0; csN <= 1'b0; state <= S_XFER;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R6
  ready_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !csN);

  // R7
  prog_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(progMode) |-> $past(busy));

  // R1
  len_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (|byteCount[3:0])) |=> (done && errCode == 4'd1 && !busy));

endmodule

// File: rtl/spiProgSeq.sv
module spiProgSeq
  import spiProgPkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BYTES_W    = 24,
  parameter int POLL_TRIES = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BYTES_W-1:0] byteCount,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               spiSclk,
  output logic               spiCsN,
  output logic               spiMosi,
  input  logic               spiMiso,
  output logic               busy,
  output logic               done,
  output logic [3:0]         errCode,
  output logic               progMode
);
  localparam int WAIT_CYCLES = CLK_HZ / 1000 + 1;

  shiftCmd_t  shCmd;
  logic       byteDone;
  logic [7:0] rxByte;

  spiProgCtrl #(
    .BYTES_W(BYTES_W), .POLL_TRIES(POLL_TRIES), .WAIT_CYCLES(WAIT_CYCLES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .byteDone(byteDone), .rxByte(rxByte), .cmd(shCmd), .csN(spiCsN),
    .busy(busy), .done(done), .errCode(errCode), .progMode(progMode)
  );

  spiProgShifter shifter (
    .clk(clk), .rstN(rstN), .cmd(shCmd), .miso(spiMiso),
    .sclk(spiSclk), .mosi(spiMosi), .byteDone(byteDone), .rxByte(rxByte)
  );

endmodule

// File: tb/tb_spiProgSeq.sv
module tb_spiProgSeq;
  localparam int CLK_HZ = 50000;
  localparam int BYTES_W = 12;
  localparam int TRIES = 8;
  localparam int WAITC = CLK_HZ / 1000 + 1;

  logic clk = 0, rstN = 0, start = 0, inValid = 0;
  logic [BYTES_W-1:0] byteCount = '0;
  logic [7:0] inData = '0;
  logic inReady, spiSclk, spiCsN, spiMosi, spiMiso, busy, done, progMode;
  logic [3:0] errCode;

  spiProgSeq #(.CLK_HZ(CLK_HZ), .BYTES_W(BYTES_W), .POLL_TRIES(TRIES)) dut (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount), .inData(inData),
    .inValid(inValid), .inReady(inReady), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .busy(busy), .done(done),
    .errCode(errCode), .progMode(progMode));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(negedge clk) cyc++;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // ---- target model ----
  int busyLeft = 0, notReadyLeft = 0, errAfter = 99, glitch = 0;
  logic [31:0] replyVal = '0;
  int bitN = 0, winBytes = 0, statParity = 0, cmdCount = 0, frameIdx = 0;
  int seqErrs = 0, dataErrs = 0, winCount = 0, statCount = 0, statBeforeRd = 0;
  int gapCyc = -1, disEnd = 0, measuring = 0;
  logic progAtEn = 0, progAtFrame = 0;
  logic [7:0] slvOut = '0, slvIn = '0, winOp = '0, curStat = '0, lastStat = '0;
  logic [7:0] cmdLog [64];
  assign spiMiso = slvOut[7];

  always @(negedge spiCsN) begin
    bitN = 0; winBytes = 0; winCount++;
    if (measuring != 0) begin gapCyc = cyc - disEnd; measuring = 0; end
    if (glitch != 0 && statParity == 0) curStat = 8'h08;
    else if (busyLeft > 0) begin curStat = 8'h01; busyLeft--; end
    else if (cmdCount >= errAfter) curStat = 8'h04;
    else if (notReadyLeft > 0 && cmdCount == 1) begin curStat = 8'h00; notReadyLeft--; end
    else curStat = 8'h02;
    slvOut = curStat;
  end

  always @(posedge spiSclk) begin
    slvIn = {slvIn[6:0], spiMosi};
    bitN++;
    if (bitN % 8 == 0) begin
      if (winBytes == 0) begin
        winOp = slvIn;
        if (slvIn != 8'h00) begin
          if (lastStat[0] || (|lastStat[3:2]) || (slvIn == 8'h01 && !lastStat[1])) seqErrs++;
          lastStat = 8'h01;
          if (cmdCount < 64) cmdLog[cmdCount] = slvIn;
          if (slvIn == 8'h0B) progAtEn = progMode;
          if (slvIn == 8'hEE && frameIdx == 0) progAtFrame = progMode;
          cmdCount++;
        end
      end else if (winOp == 8'hEE) begin
        if (slvIn != 8'((frameIdx * 16 + winBytes - 1) * 7 + 3)) dataErrs++;
      end
      winBytes++;
    end
  end

  always @(negedge spiSclk) begin
    if (bitN % 8 == 0)
      slvOut = (winOp == 8'h01 && winBytes >= 1 && winBytes <= 4) ? replyVal[8*(winBytes-1) +: 8] : 8'h00;
    else
      slvOut = {slvOut[6:0], 1'b0};
  end

  always @(posedge spiCsN) begin
    if (winOp == 8'h00 && winBytes == 1) begin
      lastStat = curStat; statParity ^= 1; statCount++;
      if (cmdCount == 1) statBeforeRd++;
    end else begin
      statParity = 0;
      if (winOp == 8'hEE) frameIdx++;
      if (winOp == 8'h0C) begin disEnd = cyc; measuring = 1; end
    end
  end

  // ---- stream feeder ----
  int feedIdx = 0;
  bit acc = 0, feedOn = 0;
  always @(negedge clk) begin
    if (acc) feedIdx++;
    inValid = feedOn && (cyc % 3 != 0);
    inData = 8'(feedIdx * 7 + 3);
    acc = inValid && inReady;
  end

  function automatic logic [7:0] expOp(int k, int nFr);
    if (k == 0) return 8'h0B;
    if (k == 1) return 8'h01;
    if (k == 2) return 8'hAE;
    if (k < 3 + nFr) return 8'hEE;
    if (k == 3 + nFr) return 8'h0C;
    return 8'h23;
  endfunction

  task automatic runSession(input int nBytes, input int bsy, input logic [31:0] rep,
                            input int eAfter, input int glt, input int nRdy);
    @(negedge clk); rstN = 0; feedOn = 0;
    busyLeft = bsy; replyVal = rep; errAfter = eAfter; glitch = glt; notReadyLeft = nRdy;
    cmdCount = 0; frameIdx = 0; seqErrs = 0; dataErrs = 0; winCount = 0; statCount = 0;
    statBeforeRd = 0; statParity = 0; lastStat = 8'h01; gapCyc = -1; measuring = 0;
    winOp = 8'h00; progAtEn = 0; progAtFrame = 0;
    repeat (2) @(negedge clk);
    rstN = 1; feedIdx = 0; acc = 0; feedOn = 1;
    @(negedge clk);
    start = 1; byteCount = BYTES_W'(nBytes);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      start = 0;
      if (done) break;
    end
  endtask

  typedef struct packed {
    int bytes; int bsy; logic [31:0] rep; int eAfter; int glt; int expErr; int expCmds;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32, 0, 32'h0,        99, 1, 0, 7},
    '{16, 3, 32'h0,        99, 0, 0, 6},
    '{0,  0, 32'h0,        99, 1, 0, 5},
    '{40, 0, 32'h0,        99, 0, 1, 0},
    '{48, 0, 32'h00010000, 99, 1, 3, 2},
    '{32, 0, 32'h0,         2, 0, 4, 2},
    '{32, 0, 32'h0,         4, 1, 5, 4},
    '{16, 0, 32'h0,         4, 0, 6, 4},
    '{16, 0, 32'h0,         5, 0, 7, 5}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(spiCsN == 1, "R11 csN after reset", int'(spiCsN), 1);
    check(!busy && !done, "R11 busy/done after reset", int'({busy, done}), 0);
    check(errCode == 0, "R11 errCode after reset", int'(errCode), 0);
    check(!progMode && !inReady, "R11 progMode/inReady after reset", int'({progMode, inReady}), 0);

    for (int v = 0; v < NV; v++) begin
      runSession(VECS[v].bytes, VECS[v].bsy, VECS[v].rep, VECS[v].eAfter, VECS[v].glt, 0);
      check(done == 1, $sformatf("R11 vector %0d done seen", v), int'(done), 1);
      check(errCode == 4'(VECS[v].expErr), $sformatf("R9/R5/R1 vector %0d error code", v),
            int'(errCode), VECS[v].expErr);
      if (VECS[v].glt != 0)
        check(errCode == 4'(VECS[v].expErr), $sformatf("R12 vector %0d glitch ignored", v),
              int'(errCode), VECS[v].expErr);
      check(cmdCount == VECS[v].expCmds, $sformatf("R2 vector %0d command count", v),
            cmdCount, VECS[v].expCmds);
      for (int k = 0; k < VECS[v].expCmds; k++)
        check(cmdLog[k] == expOp(k, VECS[v].bytes / 16), $sformatf("R2 vector %0d opcode %0d", v, k),
              int'(cmdLog[k]), int'(expOp(k, VECS[v].bytes / 16)));
      check(seqErrs == 0, $sformatf("R3 vector %0d status before commands", v), seqErrs, 0);
      check(dataErrs == 0, $sformatf("R6 vector %0d frame data", v), dataErrs, 0);
      check(progMode == (VECS[v].expErr >= 5), $sformatf("R7 vector %0d program flag", v),
            int'(progMode), int'(VECS[v].expErr >= 5));
      if (VECS[v].expErr == 0)
        check(feedIdx == VECS[v].bytes, $sformatf("R6 vector %0d bytes consumed", v), feedIdx, VECS[v].bytes);
      if (VECS[v].expErr == 1)
        check(winCount == 0, "R1 no chip select on bad length", winCount, 0);
      @(negedge clk);
      check(!done && !busy && spiCsN, $sformatf("R11 vector %0d idle after end", v),
            int'({done, busy, spiCsN}), 1);
    end

    // R10 timeout with a target that stays busy
    runSession(32, 1000, 32'h0, 99, 0, 0);
    check(errCode == 4'd2, "R10 timeout phase", int'(errCode), 2);
    check(statCount == 2 * TRIES, "R10 status windows before timeout", statCount, 2 * TRIES);
    check(cmdCount == 0 && spiCsN, "R10 no command after timeout", cmdCount, 0);

    // R4 ready arrives late before the fetch
    runSession(16, 0, 32'h0, 99, 0, 3);
    check(errCode == 0, "R4 session with late ready", int'(errCode), 0);
    check(seqErrs == 0, "R4 fetch only after ready", seqErrs, 0);
    check(statBeforeRd == 4, "R4 polls before fetch", statBeforeRd, 4);

    // R8 release delay and R7 program flag timing
    runSession(32, 0, 32'h0, 99, 0, 0);
    check(gapCyc >= WAITC && gapCyc <= WAITC + 3, "R8 delay before release", gapCyc, WAITC + 1);
    check(progAtEn == 0, "R7 flag low at session start", int'(progAtEn), 0);
    check(progAtFrame == 1, "R7 flag high during frames", int'(progAtFrame), 1);
    check(progMode == 0, "R7 flag low after release", int'(progMode), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule